// File: doc/BRIEF.md
# Serial Conversion Sequencer for a 12-bit Successive-Approximation Converter

This block is the digital controller of a 12-bit successive-approximation converter. A rising edge on `conv_start` puts the track/hold flag into hold and starts a conversion. The conversion lasts a fixed number of rising edges of an internal master clock. The master clock comes from the system clock through a divider.

While the conversion runs, the block sends a 16-bit serial word on an open-drain data line. The word is four zeros followed by the two's-complement result, most significant bit first. A frame strobe marks the word, and the master clock is sent out as the serial clock.

The `cont_clk` input selects how the serial clock behaves:
- When `cont_clk` is high, the serial clock runs at all times.
- When `cont_clk` is low, the clock stops between conversions and its output enable is released, so several converters can share one serial bus.

The result comes from one of two sources, chosen by a parameter:
- A parallel input, captured when the conversion starts.
- A behavioural successive-approximation loop. It presents a trial code and reads back one comparator bit per master-clock rising edge.

Top module: `sar_adc_serial_ctl`

## Requirements
- R1: The clock edge that samples `conv_start` high after it was low, while idle, is the start edge. From that edge `hold` is 1 and `frame_oe` is 1.
- R2: The serial word is 16 bits long: four 0 bits, then the 12-bit result, MSB first. Each bit is valid at a falling edge of `sclk`, and the first 0 is valid at the first falling edge after the start edge. Data changes only on rising edges of `sclk`.
- R3: `frame_oe` stays 1 through the 16th falling edge of `sclk` after the start edge. It returns to 0 one system-clock cycle later, and it is never 1 outside a conversion.
- R4: With `cont_clk` = 1, a conversion ends on the 19th rising edge of `sclk` after the start edge. If an `sclk` rising edge happens on the start edge itself, the conversion ends on the 20th rising edge instead.
- R5: With `cont_clk` = 0, a conversion always ends on the 19th rising edge of `sclk`. While idle in this mode, `sclk_oe` is 0 and `sclk` is 0.
- R6: With `cont_clk` = 1, `sclk_oe` stays 1 and `sclk` keeps toggling while idle.
- R7: A rising edge of `conv_start` during a conversion is ignored. The length and the word of the running conversion are unchanged.
- R8: `done` is a single-cycle pulse, one per conversion. It falls in the cycle where `frame_oe` returns to 0.
- R9: `hold` returns to 0 on the rising edge of `sclk` that ends the conversion. During a conversion in either mode, `sclk_oe` is 1.
- R10: In the comparator variant, `dac_trial` shows the trial code in two's complement, and `cmp_in` = 1 means the input is at or above that trial code. The serial word carries the code that results, from 0x800 (most negative) to 0x7FF (most positive).
- R11: In the parallel variant, `result_in` is captured on the start edge. Later changes to it do not reach the word.
- R12: The data and frame lines are open-drain. An enable of 1 pulls the line to 0, and a released line reads 1. When idle, `sdata_oe` and `frame_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Conversion start, acts on its rising edge |
| cont_clk | input | 1 | 1 = serial clock runs all the time, 0 = gated between conversions |
| result_in | input | RES_W | Parallel result (parallel variant) |
| cmp_in | input | 1 | Comparator bit: input at or above trial code (comparator variant) |
| dac_trial | output | RES_W | Trial code in two's complement (comparator variant) |
| hold | output | 1 | Track/hold flag, 1 = hold |
| sclk | output | 1 | Serial clock (the master clock) |
| sclk_oe | output | 1 | Output enable of the serial clock |
| sdata_oe | output | 1 | Pulls the data line low when 1 |
| frame_oe | output | 1 | Pulls the frame strobe low when 1 |
| done | output | 1 | One-cycle pulse after the last bit has been sent |

## Verification
The assertions check, on every cycle, that:
- the frame lies inside the conversion;
- the edge counter never restarts while a conversion is busy;
- gated-mode conversions use the 19-edge target;
- the falling-edge counter stays in range;
- every `done` pulse coincides with the frame being released.

Only the bench scenarios can show the serial word bit for bit and the 19/20-edge choice against the start phase. The same holds for ignored restarts, for clock gating while idle, and for the capture of the parallel input. The bench observes these at the pins while it sweeps result codes, start phases and both clock modes.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;
  // master-clock edge events, valid for one system-clock cycle
  typedef struct packed {
    logic rise;
    logic fall;
  } mclk_evt_t;
endpackage

// File: rtl/sar_clkgen.sv
module sar_clkgen
  import sar_ctl_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      run,
  output logic      mclk,
  output mclk_evt_t evt
);
  localparam int PERIOD = 2 * HALF_DIV;
  localparam int PH_W   = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [PH_W-1:0] ph_q;

  // events flag the clock edge at which mclk changes
  assign evt.rise = run && (ph_q == PH_W'(HALF_DIV - 1));
  assign evt.fall = run && (ph_q == PH_W'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      ph_q <= '0;
      mclk <= 1'b0;
    end else begin
      ph_q <= (ph_q == PH_W'(PERIOD - 1)) ? '0 : ph_q + 1'b1;
      if (evt.rise) mclk <= 1'b1;
      if (evt.fall) mclk <= 1'b0;
    end
  end
endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int RES_W   = 12,
  parameter int CNT_W   = 5,
  parameter bit USE_SAR = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             step_en,
  input  logic [CNT_W-1:0] step_idx,
  input  logic [RES_W-1:0] result_in,
  input  logic             cmp_in,
  output logic [RES_W-1:0] result,
  output logic [RES_W-1:0] dac_trial
);
  localparam logic [RES_W-1:0] SIGN = {1'b1, {(RES_W-1){1'b0}}};

  generate
    if (USE_SAR) begin : g_sar
      logic [RES_W-1:0] ob_q;   // offset-binary accumulator
      logic [RES_W-1:0] mask;
      logic             unused_par;

      assign unused_par = ^result_in;

      always_comb begin
        for (int b = 0; b < RES_W; b++)
          mask[b] = (step_idx == CNT_W'(RES_W - 1 - b));
      end

      always_ff @(posedge clk) begin
        if (rst || start) ob_q <= '0;
        else if (step_en && cmp_in) ob_q <= ob_q | mask;
      end

      assign dac_trial = (ob_q | mask) ^ SIGN;
      assign result    = ob_q ^ SIGN;
    end else begin : g_par
      logic [RES_W-1:0] cap_q;
      logic             unused_sar;

      assign unused_sar = cmp_in ^ step_en ^ (^step_idx);

      always_ff @(posedge clk) begin
        if (rst) cap_q <= '0;
        else if (start) cap_q <= result_in;
      end

      assign result    = cap_q;
      assign dac_trial = '0;
    end
  endgenerate
endmodule

// File: rtl/sar_serializer.sv
module sar_serializer #(
  parameter int WORD_W = 16,
  parameter int RES_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             rise,
  input  logic             fall,
  input  logic [RES_W-1:0] result,
  output logic             sdo_q,
  output logic             frame_q,
  output logic             done_q
);
  localparam int LEAD = WORD_W - RES_W;
  localparam int CW   = $clog2(WORD_W + 1);

  logic [CW-1:0]     fall_cnt_q;
  logic [WORD_W-1:0] word;

  assign word = {{LEAD{1'b0}}, result};

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q    <= 1'b0;
      done_q     <= 1'b0;
      sdo_q      <= 1'b1;
      fall_cnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        frame_q    <= 1'b1;
        fall_cnt_q <= '0;
        sdo_q      <= word[WORD_W-1];
      end else if (frame_q) begin
        if (fall_cnt_q == CW'(WORD_W)) begin
          frame_q <= 1'b0;
          done_q  <= 1'b1;
          sdo_q   <= 1'b1;
        end else begin
          if (fall) fall_cnt_q <= fall_cnt_q + 1'b1;
          if (rise && fall_cnt_q != '0)
            sdo_q <= word[WORD_W - 1 - int'(fall_cnt_q)];
        end
      end
    end
  end

  // R8
  done_frame_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!frame_q && $past(frame_q)));

  // R3
  fall_bound_chk: assert property (@(posedge clk) disable iff (rst)
    frame_q |-> (fall_cnt_q <= CW'(WORD_W)));
endmodule

// File: rtl/sar_adc_serial_ctl.sv
module sar_adc_serial_ctl
  import sar_ctl_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int RES_W      = 12,
  parameter int WORD_W     = 16,
  parameter int CONV_EDGES = 19,
  parameter bit USE_SAR    = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_start,
  input  logic             cont_clk,
  input  logic [RES_W-1:0] result_in,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_trial,
  output logic             hold,
  output logic             sclk,
  output logic             sclk_oe,
  output logic             sdata_oe,
  output logic             frame_oe,
  output logic             done
);
  localparam int CNT_W = $clog2(CONV_EDGES + 2);

  logic             start_prev_q;
  logic             busy_q;
  logic [CNT_W-1:0] rise_cnt_q;
  logic [CNT_W-1:0] target_q;
  logic             start_evt;
  mclk_evt_t        evt;
  logic [RES_W-1:0] result;
  logic             sdo_q;
  logic             frame_q;

  // edges seen while busy are swallowed: start_prev still follows the pin
  assign start_evt = conv_start && !start_prev_q && !busy_q;

  sar_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk  (clk),
    .rst  (rst),
    .run  (cont_clk || busy_q),
    .mclk (sclk),
    .evt  (evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_prev_q <= 1'b0;
      busy_q       <= 1'b0;
      rise_cnt_q   <= '0;
      target_q     <= CNT_W'(CONV_EDGES);
    end else begin
      start_prev_q <= conv_start;
      if (start_evt) begin
        busy_q     <= 1'b1;
        rise_cnt_q <= '0;
        // a rising edge on the start edge itself costs one extra edge
        target_q   <= (cont_clk && evt.rise) ? CNT_W'(CONV_EDGES + 1)
                                             : CNT_W'(CONV_EDGES);
      end else if (busy_q && evt.rise) begin
        rise_cnt_q <= rise_cnt_q + 1'b1;
        if (rise_cnt_q + 1'b1 == target_q) busy_q <= 1'b0;
      end
    end
  end

  sar_result #(.RES_W(RES_W), .CNT_W(CNT_W), .USE_SAR(USE_SAR)) u_result (
    .clk       (clk),
    .rst       (rst),
    .start     (start_evt),
    .step_en   (busy_q && evt.rise && (rise_cnt_q < CNT_W'(RES_W))),
    .step_idx  (rise_cnt_q),
    .result_in (result_in),
    .cmp_in    (cmp_in),
    .result    (result),
    .dac_trial (dac_trial)
  );

  sar_serializer #(.WORD_W(WORD_W), .RES_W(RES_W)) u_ser (
    .clk     (clk),
    .rst     (rst),
    .start   (start_evt),
    .rise    (evt.rise),
    .fall    (evt.fall),
    .result  (result),
    .sdo_q   (sdo_q),
    .frame_q (frame_q),
    .done_q  (done)
  );

  assign hold     = busy_q;
  assign sclk_oe  = cont_clk || busy_q;
  assign frame_oe = frame_q;
  assign sdata_oe = frame_q && !sdo_q;

  // R3
  frame_in_conv_chk: assert property (@(posedge clk) disable iff (rst)
    frame_oe |-> busy_q);

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> (!busy_q || rise_cnt_q >= $past(rise_cnt_q)));

  // R5
  gated_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy_q) && !$past(cont_clk)) |-> (target_q == CNT_W'(CONV_EDGES)));

  // R4
  target_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (target_q == CNT_W'(CONV_EDGES) ||
                target_q == CNT_W'(CONV_EDGES + 1)));
endmodule

// File: tb/sar_adc_serial_ctl_tb.sv
module sar_adc_serial_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RES_W      = 12;
  localparam int WORD_W     = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_start = 1'b0;
  logic cont_clk = 1'b1;
  logic [RES_W-1:0] cur_sample = '0;
  logic [RES_W-1:0] par_in = '0;
  logic cmp_in;
  logic [RES_W-1:0] dac_trial, par_trial;
  logic hold, sclk, sclk_oe, sdata_oe, frame_oe, done;
  logic p_hold, p_sclk, p_sclk_oe, p_sdata_oe, p_frame_oe, p_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // comparator stub: input at or above trial code
  assign cmp_in = ($signed(dac_trial) <= $signed(cur_sample));

  sar_adc_serial_ctl u_dut (
    .clk(clk), .rst(rst), .conv_start(conv_start), .cont_clk(cont_clk),
    .result_in(par_in), .cmp_in(cmp_in), .dac_trial(dac_trial),
    .hold(hold), .sclk(sclk), .sclk_oe(sclk_oe), .sdata_oe(sdata_oe),
    .frame_oe(frame_oe), .done(done));

  sar_adc_serial_ctl #(.USE_SAR(1'b0)) u_dut_par (
    .clk(clk), .rst(rst), .conv_start(conv_start), .cont_clk(cont_clk),
    .result_in(par_in), .cmp_in(1'b0), .dac_trial(par_trial),
    .hold(p_hold), .sclk(p_sclk), .sclk_oe(p_sclk_oe), .sdata_oe(p_sdata_oe),
    .frame_oe(p_frame_oe), .done(p_done));

  // open-drain lines with modelled pull-ups
  wire sdata_line = sdata_oe ? 1'b0 : 1'b1;
  wire frame_line = frame_oe ? 1'b0 : 1'b1;

  // pin monitor
  logic sclk_p = 1'b0, hold_p = 1'b0, frame_line_p = 1'b1;
  logic [WORD_W-1:0] rx_word;
  int rx_bits, rise_tb, done_cnt, par_mis, oe_bad, toggles;

  always @(negedge clk) begin
    if (!rst) begin
      if (hold_p && !sclk_p && sclk) rise_tb++;
      if (sclk_p && !sclk && !frame_line_p) begin
        rx_word = {rx_word[WORD_W-2:0], sdata_line};
        rx_bits++;
      end
      if (done) begin
        done_cnt++;
        if (frame_oe) oe_bad++;
      end
      if (hold && !sclk_oe) oe_bad++;
      if (sclk != sclk_p) toggles++;
      if ({p_hold, p_sclk, p_sdata_oe, p_frame_oe, p_done} !=
          {hold, sclk, sdata_oe, frame_oe, done}) par_mis++;
    end
    sclk_p = sclk; hold_p = hold; frame_line_p = frame_line;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_conv(input logic [RES_W-1:0] s, input bit restart);
    logic s0, s1;
    int exp_len, wd;
    cur_sample = s;
    par_in     = s;
    @(negedge clk);
    s0 = sclk;
    rx_word = '0; rx_bits = 0; rise_tb = 0; done_cnt = 0; par_mis = 0; oe_bad = 0;
    conv_start = 1'b1;
    @(negedge clk);
    #1;
    s1 = sclk;
    check(hold && frame_oe, "R1 start", {hold, frame_oe}, 3);
    conv_start = 1'b0;
    par_in = ~s;                       // R11: change after capture
    exp_len = (cont_clk && !s0 && s1) ? 20 : 19;
    if (restart) begin
      repeat (20) @(negedge clk);
      conv_start = 1'b1;               // R7: ignored edge
      @(negedge clk);
      conv_start = 1'b0;
    end
    wd = 0;
    while (hold && wd < 1000) begin @(negedge clk); wd++; end
    check(wd < 1000, "R9 hold release", wd, 0);
    repeat (3) @(negedge clk);
    #1;
    check(rx_bits == WORD_W, "R2 bit count", rx_bits, WORD_W);
    check(rx_word == {4'b0000, s}, "R2 R10 word", rx_word, {4'b0000, s});
    check(rise_tb == exp_len, cont_clk ? "R4 length" : "R5 length", rise_tb, exp_len);
    if (restart) check(rise_tb == exp_len, "R7 restart ignored", rise_tb, exp_len);
    check(done_cnt == 1, "R8 done pulses", done_cnt, 1);
    check(oe_bad == 0, "R8 R9 enables", oe_bad, 0);
    check(par_mis == 0, "R11 parallel variant", par_mis, 0);
    check(!hold && !frame_oe && !sdata_oe, "R12 R3 released",
          {hold, frame_oe, sdata_oe}, 0);
    if (!cont_clk) check(!sclk_oe && !sclk, "R5 idle gated", {sclk_oe, sclk}, 0);
    else begin
      toggles = 0;
      repeat (8) @(negedge clk);
      #1;
      check(sclk_oe && toggles > 0, "R6 idle continuous", toggles, 4);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(!hold && !frame_oe && !sdata_oe && !done && sclk_oe, "R12 reset state",
          {hold, frame_oe, sdata_oe, done, sclk_oe}, 1);
    // corner codes in both modes
    run_conv(12'h800, 1'b0);
    run_conv(12'h7FF, 1'b0);
    cont_clk = 1'b0;
    repeat (4) @(negedge clk);
    run_conv(12'h000, 1'b0);
    run_conv(12'hFFF, 1'b1);
    // sweep codes, start phases and modes
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      cont_clk = (i < 32);
      repeat (i % 4) @(negedge clk);
      run_conv(RES_W'(i * 65 + (i % 7)), (i % 5) == 0);
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule